// File: doc/BRIEF.md
# Displacement and Branch Address Generator

This block is a purely combinational address unit for a processor whose instructions are all 16 bits wide. It receives the instruction word together with the current program counter, the condition flag, the value of the base register that the instruction names, the global base register and a flag saying that the instruction sits in a branch delay slot. From these it forms either a branch target or the effective address of a load or store. It also reports whether the branch is taken, the access size for the memory stage, and the return address for a call.

It covers short conditional branches (with and without delay slot), long unconditional branches and calls, program-counter-relative word and long loads, program-counter-relative address generation, and displacement addressing against a general register or the global base register. A branch or program-counter-relative instruction that arrives in a delay slot raises an illegal-slot flag and produces no address. Register reads, memory access and writeback belong to the surrounding pipeline.

Top module: `disp_branch_agu`

## Requirements
- R1: For top nibble 1010 (jump) and 1011 (call) the address is PC + 4 + (sign-extended insn[11:0] shifted left by 1), valid and taken are 1, and the size code is 3 (no access).
- R2: For a call (top nibble 1011) the link output is PC + 4 with link valid 1; for every other word link valid is 0 and the link output is 0.
- R3: Upper bytes 0x89 (branch if true), 0x8B (branch if false), 0x8D (branch if true, delayed) and 0x8F (branch if false, delayed) give PC + 4 + (sign-extended insn[7:0] shifted left by 1) with valid 1 and size code 3; taken is the flag for the true forms and its inverse for the false forms.
- R4: When the delay-slot input is 1 and the word is any form of R1, R3, R5 or R6, the illegal-slot output is 1 while valid, taken and link valid are 0, address and link are 0 and the size code is 3; illegal-slot is 0 in every other case.
- R5: Upper nibble 1101 (long load) and upper byte 0xC7 (address generation) give ((PC + 4) with its two low bits cleared) + (zero-extended insn[7:0] shifted left by 2); the size code is 2 for the load and 3 for address generation.
- R6: Upper nibble 1001 (word load) gives PC + 4 + (zero-extended insn[7:0] shifted left by 1) with no alignment, size code 1.
- R7: Register-relative forms add a zero-extended insn[3:0] to the base register: upper bytes 0x80 and 0x84 unscaled with size 0, 0x81 and 0x85 shifted by 1 with size 1, nibbles 0001 and 0101 shifted by 2 with size 2; these stay valid inside a delay slot.
- R8: Global-base forms add zero-extended insn[7:0] to the global base register: upper bytes 0xC0/0xC4 unscaled size 0, 0xC1/0xC5 shifted by 1 size 1, 0xC2/0xC6 shifted by 2 size 2.
- R9: All sums wrap modulo 2^32.
- R10: Any other word gives valid 0, taken 0, illegal-slot 0, link valid 0, address 0 and size code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insnWord | input | 16 | Instruction word being decoded |
| pcIn | input | ADDR_W | Address of that instruction |
| tFlag | input | 1 | Condition flag used by conditional branches |
| baseReg | input | ADDR_W | Value of the general register named as base |
| gbrIn | input | ADDR_W | Global base register value |
| inDelaySlot | input | 1 | Instruction occupies a delay slot |
| effAddr | output | ADDR_W | Branch target or effective address, 0 when not valid |
| addrValid | output | 1 | effAddr holds a result |
| branchTaken | output | 1 | The branch goes to effAddr |
| illegalSlot | output | 1 | Illegal-slot exception request |
| linkAddr | output | ADDR_W | Return address for a call, else 0 |
| linkValid | output | 1 | linkAddr holds a return address |
| accSize | output | 2 | 0 byte, 1 word, 2 long, 3 no memory access |

## Verification
The two functions that collide are branch resolution and the delay-slot guard: a call whose condition would make it taken, or a conditional branch with the flag set to take it, can arrive with the slot flag high. Random stimulus raises the slot flag on about a quarter of all words with random flag values, and directed cases put a call and a taken conditional branch into a slot. A reference model judges that the exception wins: taken, valid and link valid must all be low while illegal-slot is high, and register- and global-base forms in the same situation must still yield their address.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_NONE = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    DX_ZX4  = 2'd0,
    DX_ZX8  = 2'd1,
    DX_SX8  = 2'd2,
    DX_SX12 = 2'd3
  } dispKind_e;

  typedef enum logic [1:0] {
    BS_PC4     = 2'd0,
    BS_PC4_AL  = 2'd1,
    BS_REG     = 2'd2,
    BS_GBR     = 2'd3
  } baseSel_e;

  typedef struct packed {
    logic      valid;
    logic      illegal;
    logic      taken;
    logic      link;
    dispKind_e dispKind;
    baseSel_e  baseSel;
    logic [1:0] scale;
    accSize_e  size;
  } aguStrobes_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [7:0]  opHigh,
  input  logic        tFlag,
  input  logic        inDelaySlot,
  output aguStrobes_t strb
);
  logic [3:0] nib;
  logic       pcRelated;
  aguStrobes_t raw;

  assign nib = opHigh[7:4];

  always_comb begin
    raw = '{valid: 1'b0, illegal: 1'b0, taken: 1'b0, link: 1'b0,
            dispKind: DX_ZX4, baseSel: BS_PC4, scale: 2'd0, size: SZ_NONE};
    pcRelated = 1'b0;
    if (nib == 4'hA || nib == 4'hB) begin
      raw.valid = 1'b1;  raw.taken = 1'b1;  raw.link = opHigh[4];
      raw.dispKind = DX_SX12;  raw.scale = 2'd1;
      pcRelated = 1'b1;
    end else if (opHigh == 8'h89 || opHigh == 8'h8B ||
                 opHigh == 8'h8D || opHigh == 8'h8F) begin
      raw.valid = 1'b1;
      raw.taken = opHigh[1] ? ~tFlag : tFlag;
      raw.dispKind = DX_SX8;  raw.scale = 2'd1;
      pcRelated = 1'b1;
    end else if (nib == 4'h9) begin
      raw.valid = 1'b1;  raw.dispKind = DX_ZX8;  raw.scale = 2'd1;
      raw.size = SZ_WORD;
      pcRelated = 1'b1;
    end else if (nib == 4'hD || opHigh == 8'hC7) begin
      raw.valid = 1'b1;  raw.dispKind = DX_ZX8;  raw.scale = 2'd2;
      raw.baseSel = BS_PC4_AL;
      raw.size = (nib == 4'hD) ? SZ_LONG : SZ_NONE;
      pcRelated = 1'b1;
    end else if (opHigh == 8'h80 || opHigh == 8'h81 ||
                 opHigh == 8'h84 || opHigh == 8'h85) begin
      raw.valid = 1'b1;  raw.dispKind = DX_ZX4;  raw.baseSel = BS_REG;
      raw.scale = {1'b0, opHigh[0]};
      raw.size = opHigh[0] ? SZ_WORD : SZ_BYTE;
    end else if (nib == 4'h1 || nib == 4'h5) begin
      raw.valid = 1'b1;  raw.dispKind = DX_ZX4;  raw.baseSel = BS_REG;
      raw.scale = 2'd2;  raw.size = SZ_LONG;
    end else if (nib == 4'hC && opHigh[1:0] != 2'b11 && opHigh[3] == 1'b0) begin
      raw.valid = 1'b1;  raw.dispKind = DX_ZX8;  raw.baseSel = BS_GBR;
      raw.scale = opHigh[1:0];
      raw.size = accSize_e'(opHigh[1:0]);
    end

    strb = raw;
    if (pcRelated && inDelaySlot) begin
      strb.valid   = 1'b0;
      strb.taken   = 1'b0;
      strb.link    = 1'b0;
      strb.illegal = 1'b1;
      strb.size    = SZ_NONE;
    end
  end
endmodule

// File: rtl/agu_dispext.sv
module agu_dispext
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [11:0]       field,
  input  dispKind_e         kind,
  input  logic [1:0]        scale,
  output logic [ADDR_W-1:0] offset
);
  localparam int PAD4  = ADDR_W - 4;
  localparam int PAD8  = ADDR_W - 8;
  localparam int PAD12 = ADDR_W - 12;

  logic [ADDR_W-1:0] ext;

  generate
    if (ADDR_W < 16) begin : g_badWidth
      initial $error("agu_dispext: ADDR_W must be at least 16");
    end
  endgenerate

  always_comb begin
    unique case (kind)
      DX_ZX4:  ext = {{PAD4{1'b0}}, field[3:0]};
      DX_ZX8:  ext = {{PAD8{1'b0}}, field[7:0]};
      DX_SX8:  ext = {{PAD8{field[7]}}, field[7:0]};
      default: ext = {{PAD12{field[11]}}, field};
    endcase
    offset = ext << scale;
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  aguStrobes_t       strb,
  input  logic [11:0]       dispField,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] gbrIn,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] linkAddr
);
  localparam logic [ADDR_W-1:0] PC_STEP   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;

  agu_dispext #(.ADDR_W(ADDR_W)) i_dispext (
    .field  (dispField),
    .kind   (strb.dispKind),
    .scale  (strb.scale),
    .offset (offset)
  );

  assign pcNext = pcIn + PC_STEP;

  always_comb begin
    unique case (strb.baseSel)
      BS_PC4:    baseVal = pcNext;
      BS_PC4_AL: baseVal = pcNext & ALIGN_MSK;
      BS_REG:    baseVal = baseReg;
      default:   baseVal = gbrIn;
    endcase
  end

  assign sum      = baseVal + offset;
  assign effAddr  = strb.valid ? sum : '0;
  assign linkAddr = strb.link ? pcNext : '0;
endmodule

// File: rtl/disp_branch_agu.sv
module disp_branch_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [15:0]       insnWord,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              tFlag,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] gbrIn,
  input  logic              inDelaySlot,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic              branchTaken,
  output logic              illegalSlot,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              linkValid,
  output logic [1:0]        accSize
);
  aguStrobes_t strb;

  agu_decode i_decode (
    .opHigh      (insnWord[15:8]),
    .tFlag       (tFlag),
    .inDelaySlot (inDelaySlot),
    .strb        (strb)
  );

  agu_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .strb      (strb),
    .dispField (insnWord[11:0]),
    .pcIn      (pcIn),
    .baseReg   (baseReg),
    .gbrIn     (gbrIn),
    .effAddr   (effAddr),
    .linkAddr  (linkAddr)
  );

  assign addrValid   = strb.valid;
  assign branchTaken = strb.taken;
  assign illegalSlot = strb.illegal;
  assign linkValid   = strb.link;
  assign accSize     = strb.size;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W = 32
) (
  input logic [15:0]       insnWord,
  input logic [ADDR_W-1:0] pcIn,
  input logic              inDelaySlot,
  input logic [ADDR_W-1:0] effAddr,
  input logic              addrValid,
  input logic              branchTaken,
  input logic              illegalSlot,
  input logic [ADDR_W-1:0] linkAddr,
  input logic              linkValid
);
  logic known;
  assign known = !$isunknown({insnWord, pcIn, inDelaySlot, effAddr, addrValid,
                              branchTaken, illegalSlot, linkAddr, linkValid});

  always_comb begin
    if (known) begin
      // R4: exception and a produced address never coexist
      assert_slot_exclusive_R4: assert ($onehot0({addrValid, illegalSlot}))
        else $error("illegal-slot together with a valid address");
      // R4: exception only inside a delay slot
      assert_slot_needs_flag_R4: assert (!illegalSlot || inDelaySlot)
        else $error("illegal-slot without delay-slot input");
      // R3: a taken branch always carries a target
      assert_taken_has_target_R3: assert (!branchTaken || addrValid)
        else $error("taken without valid target");
      // R2: return address is the instruction after the call plus one
      assert_link_value_R2: assert (!linkValid || linkAddr == pcIn + ADDR_W'(4))
        else $error("link address mismatch");
      // R5: long load addresses land on a 4-byte boundary
      assert_long_aligned_R5: assert (!(addrValid && insnWord[15:12] == 4'hD)
                                      || effAddr[1:0] == 2'b00)
        else $error("unaligned long load address");
      // R1: branch targets keep the parity of the PC
      assert_branch_parity_R1: assert (!branchTaken || effAddr[0] == pcIn[0])
        else $error("branch target parity broken");
    end
  end
endmodule

bind disp_branch_agu agu_checker #(.ADDR_W(ADDR_W)) i_agu_checker (
  .insnWord    (insnWord),
  .pcIn        (pcIn),
  .inDelaySlot (inDelaySlot),
  .effAddr     (effAddr),
  .addrValid   (addrValid),
  .branchTaken (branchTaken),
  .illegalSlot (illegalSlot),
  .linkAddr    (linkAddr),
  .linkValid   (linkValid)
);

// File: tb/test_disp_branch_agu.sv
`timescale 1ns/1ps
module test_disp_branch_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] insnWord = 16'h0000;
  logic [31:0] pcIn = '0, baseReg = '0, gbrIn = '0;
  logic        tFlag = 1'b0, inDelaySlot = 1'b0;
  logic [31:0] effAddr, linkAddr;
  logic        addrValid, branchTaken, illegalSlot, linkValid;
  logic [1:0]  accSize;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  disp_branch_agu i_disp_branch_agu (
    .insnWord(insnWord), .pcIn(pcIn), .tFlag(tFlag), .baseReg(baseReg),
    .gbrIn(gbrIn), .inDelaySlot(inDelaySlot), .effAddr(effAddr),
    .addrValid(addrValid), .branchTaken(branchTaken), .illegalSlot(illegalSlot),
    .linkAddr(linkAddr), .linkValid(linkValid), .accSize(accSize)
  );

  typedef struct packed {
    logic        valid, taken, illegal, link;
    logic [1:0]  size;
    logic [31:0] addr, ret;
  } expect_t;

  function automatic expect_t model(input logic [15:0] w, input logic [31:0] pc,
                                    input logic t, input logic [31:0] rb,
                                    input logic [31:0] gb, input logic slot,
                                    output string req);
    expect_t e;
    logic [7:0]  hb = w[15:8];
    logic [3:0]  hn = w[15:12];
    logic [31:0] nxt = pc + 32'd4;
    bit pcForm = 0;
    e = '0; e.size = 2'd3; req = "R10";
    if (hn == 4'hA || hn == 4'hB) begin
      e.valid = 1; e.taken = 1; pcForm = 1;
      e.addr = nxt + {{19{w[11]}}, w[11:0], 1'b0};
      if (hn == 4'hB) begin e.link = 1; e.ret = nxt; req = "R2"; end else req = "R1";
    end else if (hb == 8'h89 || hb == 8'h8D || hb == 8'h8B || hb == 8'h8F) begin
      e.valid = 1; pcForm = 1; req = "R3";
      e.taken = (hb == 8'h89 || hb == 8'h8D) ? t : !t;
      e.addr = nxt + {{23{w[7]}}, w[7:0], 1'b0};
    end else if (hn == 4'h9) begin
      e.valid = 1; pcForm = 1; req = "R6"; e.size = 2'd1;
      e.addr = nxt + {23'd0, w[7:0], 1'b0};
    end else if (hn == 4'hD || hb == 8'hC7) begin
      e.valid = 1; pcForm = 1; req = "R5"; e.size = (hn == 4'hD) ? 2'd2 : 2'd3;
      e.addr = {nxt[31:2], 2'b00} + {22'd0, w[7:0], 2'b00};
    end else if (hb == 8'h80 || hb == 8'h84) begin
      e.valid = 1; req = "R7"; e.size = 2'd0; e.addr = rb + {28'd0, w[3:0]};
    end else if (hb == 8'h81 || hb == 8'h85) begin
      e.valid = 1; req = "R7"; e.size = 2'd1; e.addr = rb + {27'd0, w[3:0], 1'b0};
    end else if (hn == 4'h1 || hn == 4'h5) begin
      e.valid = 1; req = "R7"; e.size = 2'd2; e.addr = rb + {26'd0, w[3:0], 2'b00};
    end else if (hb == 8'hC0 || hb == 8'hC4) begin
      e.valid = 1; req = "R8"; e.size = 2'd0; e.addr = gb + {24'd0, w[7:0]};
    end else if (hb == 8'hC1 || hb == 8'hC5) begin
      e.valid = 1; req = "R8"; e.size = 2'd1; e.addr = gb + {23'd0, w[7:0], 1'b0};
    end else if (hb == 8'hC2 || hb == 8'hC6) begin
      e.valid = 1; req = "R8"; e.size = 2'd2; e.addr = gb + {22'd0, w[7:0], 2'b00};
    end
    if (pcForm && slot) begin
      e = '0; e.illegal = 1; e.size = 2'd3; req = "R4";
    end
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [31:0] pc, input logic t,
                       input logic [31:0] rb, input logic [31:0] gb, input logic slot);
    expect_t e;
    string req;
    @(negedge clk);
    insnWord = w; pcIn = pc; tFlag = t; baseReg = rb; gbrIn = gb; inDelaySlot = slot;
    #1;
    e = model(w, pc, t, rb, gb, slot, req);
    check(req, "valid",   {31'd0, addrValid},   {31'd0, e.valid});
    check(req, "taken",   {31'd0, branchTaken}, {31'd0, e.taken});
    check(req, "illegal", {31'd0, illegalSlot}, {31'd0, e.illegal});
    check(req, "linkV",   {31'd0, linkValid},   {31'd0, e.link});
    check(req, "size",    {30'd0, accSize},     {30'd0, e.size});
    check(req, "addr",    effAddr,              e.addr);
    check(req, "link",    linkAddr,             e.ret);
  endtask

  function automatic logic [15:0] pickWord(input int unsigned sel, input logic [15:0] r);
    case (sel % 14)
      0:  return {4'hA, r[11:0]};
      1:  return {4'hB, r[11:0]};
      2:  return {6'b100010, r[9], 1'b1, r[7:0]};
      3:  return {4'h9, r[11:0]};
      4:  return {4'hD, r[11:0]};
      5:  return {8'hC7, r[7:0]};
      6:  return {5'b10000, r[10], 1'b0, r[8], r[7:0]};
      7:  return {1'b0, r[14], 2'b01, r[11:0]};
      8:  return {6'b110001, r[9], 1'b0, r[7:0]};
      9:  return {6'b110000, r[9:8] == 2'b11 ? 2'b10 : r[9:8], r[7:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(posedge clk);
    // Reset state: idle word, all outputs quiet (R10)
    @(negedge clk); #1;
    check("R10", "reset valid", {31'd0, addrValid}, 32'd0);
    check("R10", "reset addr", effAddr, 32'd0);
    check("R10", "reset size", {30'd0, accSize}, 32'd3);
    rstN = 1'b1;

    // R9: most negative jump wraps below zero
    apply(16'hA800, 32'h0000_0100, 0, 0, 0, 0);
    // R2: call with positive displacement, link = PC+4
    apply(16'hB7FF, 32'h8000_0000, 0, 0, 0, 0);
    // R3: true form with flag 1, false form with flag 1, negative displacement
    apply(16'h8980, 32'h0000_2000, 1, 0, 0, 0);
    apply(16'h8B80, 32'h0000_2000, 1, 0, 0, 0);
    apply(16'h8F01, 32'h0000_2000, 0, 0, 0, 0);
    // R5: PC not 4-aligned after +4 gets masked
    apply(16'hD301, 32'h0000_1002, 0, 0, 0, 0);
    apply(16'hC7FF, 32'hFFFF_FFFE, 0, 0, 0, 0);
    // R6: no masking for word load
    apply(16'h9300, 32'h0000_1002, 0, 0, 0, 0);
    // R4: taken call and taken branch inside a slot
    apply(16'hB010, 32'h0000_4000, 1, 0, 0, 1);
    apply(16'h8D10, 32'h0000_4000, 1, 0, 0, 1);
    apply(16'hC710, 32'h0000_4000, 1, 0, 0, 1);
    // R7: register forms stay valid in a slot
    apply(16'h855F, 0, 0, 32'h0000_1000, 0, 1);
    apply(16'h1A2F, 0, 0, 32'hFFFF_FFF0, 0, 1);
    // R8 / R9: global base long with wrap
    apply(16'hC6FF, 0, 0, 0, 32'hFFFF_FFFC, 0);
    apply(16'hC0FF, 0, 0, 0, 32'h0000_0010, 0);
    // R10: unrecognised words
    apply(16'h0009, 32'h100, 1, 1, 1, 0);
    apply(16'h8A00, 32'h100, 1, 1, 1, 1);
    apply(16'hC3FF, 32'h100, 1, 1, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      apply(pickWord($urandom, r), $urandom, 1'($urandom), $urandom, $urandom,
            ($urandom % 4) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule